// File: doc/BRIEF.md
# Dual-Address I2C Port Slave

This block is an I2C target that runs on a fast system clock and samples the serial clock and data lines through synchronizers. It answers two 7-bit addresses. Both addresses share one 4-bit selector input, and each has a fixed 3-bit prefix of its own. Behind the first address, group A, sit four output latches, four live input pins and a 4-bit interrupt mask. Behind the second address, group B, sits an 8-bit output register whose real pin levels can be read back.

A group A byte carries the fields in this order, from bit 7 down to bit 0: output 3, output 2, inputs 3..0, output 1, output 0. On a group A write, the four output bits go to the latches and bits 5..2 go to the mask. A group A read returns two bytes in turn and repeats them until the master stops. The first is the live port byte. The second is a flag byte, taken from an external change detector at the same moment as the port byte.

Each time the port byte is captured, the block emits a one-cycle strobe. The change detector uses it to resample its inputs and clear its flags. The data line is driven only through an open-drain pull-low enable.

Top module: `dual_port_i2c_slave`

## Requirements
- R1: The block acknowledges address {3'b110, addr_sel} as group A and {3'b101, addr_sel} as group B, both with R/W as bit 0 of the address byte (0 means write). Any other address gets no acknowledge and the rest of that transaction has no effect.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP releases SDA and returns the block to idle. A repeated START begins a new address phase.
- R3: Every byte of a group A write sets a_out[3]=bit7, a_out[2]=bit6, a_out[1]=bit1, a_out[0]=bit0 and irq_mask[3:0]=bits 5..2. The update takes effect at the SCL falling edge that ends the eighth data bit.
- R4: Every byte of a group B write is copied whole into b_out.
- R5: In a group A read, odd bytes return {a_out[3], a_out[2], in_pins[3:0], a_out[1], a_out[0]}. Even bytes return {2'b00, flags[3:0], 2'b00}, where flags are the chg_flags values captured with the preceding port byte.
- R6: snap_stb pulses for exactly one cycle at the SCL rising edge of the address acknowledge of every group A access. It also pulses at each master acknowledge that precedes a group A port byte. The inputs and chg_flags are captured in that same cycle.
- R7: Each group B read byte is b_pin as sampled at the SCL rising edge of the acknowledge bit before it. A pin change made after that sample first shows in the next byte.
- R8: SDA is only ever pulled low through sda_oe. Apart from START and STOP handling, sda_oe changes only after an SCL falling edge, so it stays constant while SCL is high.
- R9: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until a STOP or START.
- R10: While rst_n is low, any transaction is aborted, sda_oe is 0 and the block is idle. The outputs take their defaults: a_out=addr_sel, b_out={addr_sel, addr_sel} and irq_mask=4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset, aborts the transaction and loads the defaults |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 4 | Low four address bits, shared by both groups |
| in_pins | input | 4 | Live group A input pins |
| chg_flags | input | 4 | Change flags from the external detector |
| snap_stb | output | 1 | One-cycle resample/clear strobe for the detector |
| a_out | output | 4 | Group A output latches {O7,O6,O1,O0} |
| irq_mask | output | 4 | Interrupt mask written through group A |
| b_out | output | 8 | Group B output register |
| b_pin | input | 8 | Actual group B pin levels for readback |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it signals START or STOP. They also assume that every SCL phase lasts longer than the two-stage synchronizer plus edge detection. The bench holds each SCL half period for 12 system clocks and changes SDA six clocks after SCL falls. This keeps the block's pull-low changes and the master's own data changes clear of the high phase.

// File: rtl/dual_port_i2c_slave.sv
module dual_port_i2c_slave #(
  parameter logic [2:0] PREFIX_A = 3'b110,
  parameter logic [2:0] PREFIX_B = 3'b101,
  parameter int         SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [3:0] addr_sel,
  input  logic [3:0] in_pins,
  input  logic [3:0] chg_flags,
  output logic       snap_stb,
  output logic [3:0] a_out,
  output logic [3:0] irq_mask,
  output logic [7:0] b_out,
  input  logic [7:0] b_pin
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_ADR, ST_WR, ST_ACK_WR, ST_RD, ST_ACK_RD, ST_WAIT
  } state_t;

  state_t st;
  logic [SYNC_LEN-1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  logic [7:0] sr, tx;
  logic [3:0] bcnt, flag_hold;
  logic is_b, is_rd, phase, ack_ok;

  wire scl_s     = scl_sy[SYNC_LEN-1];
  wire sda_s     = sda_sy[SYNC_LEN-1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire hit_a     = sr[7:1] == {PREFIX_A, addr_sel};
  wire hit_b     = sr[7:1] == {PREFIX_B, addr_sel};
  wire [7:0] port_byte = {a_out[3:2], in_pins, a_out[1:0]};
  wire [7:0] flag_byte = {2'b00, flag_hold, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_LEN-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_LEN-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sr        <= '0;
      tx        <= '0;
      bcnt      <= '0;
      flag_hold <= '0;
      is_b      <= 1'b0;
      is_rd     <= 1'b0;
      phase     <= 1'b0;
      ack_ok    <= 1'b0;
      sda_oe    <= 1'b0;
      snap_stb  <= 1'b0;
      a_out     <= addr_sel;
      b_out     <= {addr_sel, addr_sel};
      irq_mask  <= 4'hF;
    end else begin
      snap_stb <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        bcnt   <= '0;
        phase  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              sr   <= {sr[6:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              if (st == ST_ADDR) begin
                if (hit_a || hit_b) begin
                  is_b   <= hit_b;
                  is_rd  <= sr[0];
                  sda_oe <= 1'b1;
                  st     <= ST_ACK_ADR;
                end else begin
                  st <= ST_WAIT;
                end
              end else begin
                if (is_b) b_out <= sr;
                else begin
                  a_out    <= {sr[7:6], sr[1:0]};
                  irq_mask <= sr[5:2];
                end
                sda_oe <= 1'b1;
                st     <= ST_ACK_WR;
              end
            end
          end
          ST_ACK_ADR: begin
            if (scl_rise) begin
              if (!is_b) begin
                flag_hold <= chg_flags;
                snap_stb  <= 1'b1;
              end
              tx    <= is_b ? b_pin : port_byte;
              phase <= 1'b1;
            end else if (scl_fall) begin
              bcnt   <= '0;
              sda_oe <= is_rd ? ~tx[7] : 1'b0;
              st     <= is_rd ? ST_RD : ST_WR;
            end
          end
          ST_ACK_WR: begin
            if (scl_fall) begin
              bcnt   <= '0;
              sda_oe <= 1'b0;
              st     <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bcnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_ACK_RD;
              end else begin
                sda_oe <= ~tx[6];
                tx     <= {tx[6:0], 1'b0};
                bcnt   <= bcnt + 4'd1;
              end
            end
          end
          ST_ACK_RD: begin
            if (scl_rise) begin
              ack_ok <= ~sda_s;
              if (!sda_s) begin
                phase <= ~phase;
                if (is_b) tx <= b_pin;
                else if (!phase) begin
                  tx        <= port_byte;
                  flag_hold <= chg_flags;
                  snap_stb  <= 1'b1;
                end else tx <= flag_byte;
              end
            end else if (scl_fall) begin
              bcnt <= '0;
              if (ack_ok) begin
                sda_oe <= ~tx[7];
                st     <= ST_RD;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_port_i2c_slave_chk.sv
module dual_port_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       snap_stb,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic [3:0] a_out,
  input logic [3:0] irq_mask,
  input logic [7:0] b_out
);
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R2
  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_det || stop_det)); // R8
  AST_SNAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_stb |=> !snap_stb); // R6
  AST_SNAP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_stb |-> $past(scl_rise)); // R6
  AST_A_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_out != $past(a_out)) || (irq_mask != $past(irq_mask))) |-> $past(scl_fall)); // R3
  AST_B_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (b_out != $past(b_out)) |-> $past(scl_fall)); // R4
endmodule

bind dual_port_i2c_slave dual_port_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .snap_stb(snap_stb),
  .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .a_out(a_out), .irq_mask(irq_mask), .b_out(b_out)
);

// File: tb/dual_port_i2c_slave_bench.sv
module dual_port_i2c_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 12;
  localparam logic [16:0] VEC [0:5] = '{
    {1'b0, 8'hC3, 8'h05}, {1'b0, 8'h3C, 8'h0A}, {1'b0, 8'h5A, 8'h0F},
    {1'b1, 8'hA5, 8'h00}, {1'b1, 8'h0F, 8'h30}, {1'b1, 8'hF0, 8'hFF}};

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic [3:0] sel = 4'b0101, pins = 4'h0, flags = 4'h0, pins_q = 4'h0;
  logic [7:0] b_force = 8'h00;
  logic sda_oe, snap_stb;
  logic [3:0] a_out, irq_mask;
  logic [7:0] b_out;
  int n_chk = 0, n_fail = 0, r8_bad = 0, snaps = 0;
  bit done = 0;

  wire line = sda_m & ~sda_oe;
  wire [7:0] b_pin = b_out ^ b_force;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_port_i2c_slave u_dual_port_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .sda_oe(sda_oe),
    .addr_sel(sel), .in_pins(pins), .chg_flags(flags), .snap_stb(snap_stb),
    .a_out(a_out), .irq_mask(irq_mask), .b_out(b_out), .b_pin(b_pin));

  always @(posedge clk) begin
    pins_q <= pins;
    if (!rst_n) flags <= '0;
    else if (snap_stb) begin flags <= '0; snaps <= snaps + 1; end
    else flags <= flags | (pins ^ pins_q);
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w8(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_w(input logic b);
    sda_m = b; w8(HALF/2); scl_m = 1; w8(HALF); scl_m = 0; w8(HALF/2);
  endtask

  task automatic bit_r(output logic b);
    logic s1;
    sda_m = 1; w8(HALF/2); scl_m = 1; w8(HALF/2); s1 = line; b = line;
    w8(HALF/2 - 1); if (line !== s1) r8_bad++;
    w8(1); scl_m = 0; w8(HALF/2);
  endtask

  task automatic i2c_start();
    sda_m = 1; w8(HALF/2); scl_m = 1; w8(HALF/2); sda_m = 0; w8(HALF/2); scl_m = 0; w8(HALF/2);
  endtask

  task automatic i2c_stop();
    sda_m = 0; w8(HALF/2); scl_m = 1; w8(HALF/2); sda_m = 1; w8(HALF);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(a); ack = ~a;
  endtask

  task automatic rd_byte(input logic m_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_r(b); d[i] = b; end
    bit_w(~m_ack);
  endtask

  function automatic logic [7:0] adr(input bit grp_b, input bit rd);
    return {grp_b ? 3'b101 : 3'b110, sel, rd};
  endfunction

  initial begin
    logic ack;
    logic [7:0] d;
    w8(5);
    // R10 reset state
    chk("R10 sda_oe in reset", sda_oe, 0);
    chk("R10 a_out default", a_out, 4'b0101);
    chk("R10 b_out default", b_out, 8'h55);
    chk("R10 mask default", irq_mask, 4'hF);
    rst_n = 1; w8(5);

    // table of single-byte writes followed by readback
    for (int k = 0; k < 6; k++) begin
      logic gb; logic [7:0] wv, pv;
      {gb, wv, pv} = VEC[k];
      if (gb) b_force = pv; else pins = pv[3:0];
      i2c_start(); wr_byte(adr(gb, 0), ack);
      chk("R1 address ack", ack, 1);
      wr_byte(wv, ack); i2c_stop();
      if (gb) chk("R4 group B write", b_out, wv);
      else begin
        chk("R3 group A outputs", a_out, {wv[7:6], wv[1:0]});
        chk("R3 group A mask", irq_mask, wv[5:2]);
      end
      i2c_start(); wr_byte(adr(gb, 1), ack); rd_byte(0, d); i2c_stop();
      if (gb) chk("R7 group B readback", d, wv ^ pv);
      else chk("R5 group A port byte", d, {wv[7:6], pv[3:0], wv[1:0]});
    end
    b_force = 0;

    // R1 foreign address ignored
    i2c_start(); wr_byte({3'b111, sel, 1'b0}, ack);
    chk("R1 foreign address nack", ack, 0);
    wr_byte(8'h00, ack); i2c_stop();
    chk("R1 foreign write no effect", b_out, 8'hF0);

    // R3 multi-byte group A write, each byte applied
    i2c_start(); wr_byte(adr(0, 0), ack);
    wr_byte(8'h81, ack); chk("R3 first byte", {a_out, irq_mask}, 8'h90);
    wr_byte(8'h7C, ack); chk("R3 second byte", {a_out, irq_mask}, 8'h4F);
    i2c_stop();
    // R4 multi-byte group B write
    i2c_start(); wr_byte(adr(1, 0), ack);
    wr_byte(8'h12, ack); chk("R4 first byte", b_out, 8'h12);
    wr_byte(8'h34, ack); chk("R4 second byte", b_out, 8'h34);
    i2c_stop();

    // R5/R6 group A port/flag interleave
    pins = 4'h0; w8(4);
    i2c_start(); wr_byte(adr(0, 0), ack); i2c_stop();
    pins = 4'b0010; w8(4);
    snaps = 0;
    i2c_start(); wr_byte(adr(0, 1), ack);
    rd_byte(1, d); chk("R5 port byte 1", d, {2'b01, 4'b0010, 2'b00});
    pins = 4'b1010;
    rd_byte(1, d); chk("R5 flag byte 1", d, {2'b00, 4'b0010, 2'b00});
    rd_byte(1, d); chk("R5 port byte 2", d, {2'b01, 4'b1010, 2'b00});
    rd_byte(0, d); chk("R5 flag byte 2", d, {2'b00, 4'b1000, 2'b00});
    i2c_stop();
    chk("R6 snapshot strobe count", snaps, 2);
    chk("R2 released after stop", sda_oe, 0);

    // R7 group B resample at ack, R9 release after NACK
    i2c_start(); wr_byte(adr(1, 1), ack);
    rd_byte(1, d); chk("R7 B byte 1", d, 8'h34);
    b_force = 8'h0F;
    rd_byte(1, d); chk("R7 B byte sampled before change", d, 8'h34);
    rd_byte(0, d); chk("R7 B byte after change", d, 8'h3B);
    rd_byte(0, d); chk("R9 no drive after nack", d, 8'hFF);
    i2c_stop();
    b_force = 0;
    chk("R8 sda stable while scl high", r8_bad, 0);

    // R2 repeated start: write then read group A
    pins = 4'b0110;
    i2c_start(); wr_byte(adr(0, 0), ack); wr_byte(8'hC1, ack);
    i2c_start(); wr_byte(adr(0, 1), ack);
    chk("R2 repeated start ack", ack, 1);
    rd_byte(0, d); i2c_stop();
    chk("R2 read after repeated start", d, {2'b11, 4'b0110, 2'b01});

    // R10 reset aborts while driving ack, new defaults
    i2c_start();
    for (int i = 7; i >= 0; i--) bit_w(adr(1, 0)>>i);
    sda_m = 1; w8(2);
    chk("R1 ack driven", sda_oe, 1);
    sel = 4'b1010; rst_n = 0; w8(3);
    chk("R10 reset releases sda", sda_oe, 0);
    chk("R10 reset b_out default", b_out, 8'hAA);
    chk("R10 reset a_out default", a_out, 4'b1010);
    i2c_stop(); rst_n = 1; w8(4);
    i2c_start(); wr_byte(adr(1, 0), ack); wr_byte(8'h66, ack); i2c_stop();
    chk("R10 works after reset", b_out, 8'h66);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule